// File: doc/BRIEF.md
# Frame Group Output Generator

This block drives twelve output pins that belong to one frame group of a TDM serial backplane port. A small register bus writes two 8-bit registers, a start register and a mode register. A 2-bit field in the mode register picks what the pins carry. They can carry static register bits. They can carry per-stream output drive enables next to four programmed pins. They can carry twelve staggered framing pulses, in normal polarity or in inverted polarity.

The framing pulses are timed against a free-running frame state counter. The counter advances once per bit clock and wraps at a configurable frame length. The block has no frame-sync input, so the frame phase is set only by the reset release. An 11-bit start quantity sets where the first pulse falls. The quantity is one less than the state number in which the pulse is seen. Each further pin pulses a fixed spacing later. Register writes go into shadow copies and become active only when the counter wraps, so a frame never holds a partial or mixed pattern. Two instances serve two groups. For group A the 8-bit enable input is wired to the output-stream enables, and for group B it is wired to the input-stream enables.

Top module: `fgo_frame_group`

## Requirements
- R1: After reset the active and shadow registers are zero (programmed-output mode), the state counter is 0 and all twelve pins are low.
- R2: Mode register bits 7:6 select the mode: 00 programmed output, 01 stream enables, 10 normal framing, 11 inverted framing. Mode register bits 5:4 have no effect on the pins.
- R3: In mode 00, pin n equals start register bit n for n = 0..7, and pins 11:8 equal mode register bits 3:0.
- R4: In mode 01, pins 3:0 equal mode register bits 3:0, and pins 11:4 equal `strm_oe[7:0]` (pin 4 = stream 0) one clock after the input is sampled. The start register has no effect.
- R5: In modes 10 and 11 the start quantity Q is {mode[2:0], start[7:0]}, an 11-bit value.
- R6: The state counter steps by one each clock from 0 to FRAME_LEN-1, then returns to 0.
- R7: In mode 10, pin k (k = 0..11) is high for exactly one clock, in the clock after the one in which the counter equals (Q + k*SPACING) mod FRAME_LEN. It is low at all other times.
- R8: In mode 11 every pin is the logical inverse of its mode 10 value, so it idles high and pulses low.
- R9: A write with `wr_addr` = 0 targets the start register and a write with `wr_addr` = 1 targets the mode register. A write has no effect on the pins until the counter wraps from FRAME_LEN-1 to 0. The new setting shows on the pins from the clock in which the counter reads 1.
- R10: The pins come from a register. Each pin value reflects the counter state, the active setting and `strm_oe` of the clock before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; the state counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 start register, 1 mode register |
| wr_data | input | 8 | Write data |
| strm_oe | input | 8 | Per-stream output drive enables from the switching logic |
| fg_pins | output | 12 | Frame group output pins |

## Verification
A register write becomes visible in the state numbered 1 of the frame that follows the write. So the bench writes in state 10 and checks the old pattern in states 63 and 0. It checks the new pattern only from state 1 onward. A framing pulse for position p is due in the state p+1 modulo the frame length. The bench follows the counter with its own frame count, and in each framing test it compares all twelve pins in every state of one complete frame, including the wrap from a position of 63 into state 0. Stream enables take one clock: they are driven at a falling edge and compared at the next falling edge.

// File: rtl/fgo_pkg.sv
package fgo_pkg;

    localparam int REG_W    = 8;
    localparam int LOW_W    = 4;
    localparam int STRM_N   = 8;
    localparam int PIN_N    = LOW_W + STRM_N;
    localparam int QHI_W    = 3;
    localparam int QTY_W    = REG_W + QHI_W;

    typedef enum logic [1:0] {
        FG_PROG = 2'b00,
        FG_OE   = 2'b01,
        FG_NORM = 2'b10,
        FG_INV  = 2'b11
    } fg_mode_e;

    // Only the fields that steer the pins are stored; bits 5:4 of the
    // mode register are dropped at write time.
    typedef struct packed {
        logic [REG_W-1:0] start;
        fg_mode_e         sel;
        logic [LOW_W-1:0] low;
    } cfg_t;

    typedef struct packed {
        logic [PIN_N-1:0] pins;
    } pin_st_t;

endpackage

// File: rtl/fgo_cfg_regs.sv
module fgo_cfg_regs
    import fgo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             commit,
    output cfg_t             act
);

    typedef struct packed {
        cfg_t shadow;
        cfg_t act;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr) begin
                st_d.shadow.sel = fg_mode_e'(wr_data[REG_W-1 -: 2]);
                st_d.shadow.low = wr_data[LOW_W-1:0];
            end else begin
                st_d.shadow.start = wr_data;
            end
        end
        // A write landing on the wrap edge waits for the following frame.
        if (commit) begin
            st_d.act = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;

endmodule

// File: rtl/fgo_state_ctr.sv
module fgo_state_ctr #(
    parameter int CNT_W     = 11,
    parameter int FRAME_LEN = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign wrap = (st_q.cnt == LAST);

endmodule

// File: rtl/fgo_pulse_match.sv
module fgo_pulse_match
    import fgo_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int FRAME_LEN = 2048,
    parameter int SPACING   = 16
) (
    input  logic [QTY_W-1:0] qty,
    input  logic [CNT_W-1:0] cnt,
    output logic [PIN_N-1:0] hit
);

    for (genvar k = 0; k < PIN_N; k++) begin : g_pin
        localparam int OFS = k * SPACING;
        logic [31:0] sum_w;
        logic [31:0] pos_w;

        always_comb begin
            sum_w  = 32'(qty) + 32'(OFS);
            pos_w  = sum_w % 32'(FRAME_LEN);
            hit[k] = (32'(cnt) == pos_w);
        end
    end

endmodule

// File: rtl/fgo_frame_group.sv
module fgo_frame_group
    import fgo_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int FRAME_LEN = 2048,
    parameter int SPACING   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [STRM_N-1:0] strm_oe,
    output logic [PIN_N-1:0]  fg_pins
);

    cfg_t             cfg_act;
    logic [CNT_W-1:0] cnt_w;
    logic             wrap_w;
    logic [QTY_W-1:0] qty_w;
    logic [PIN_N-1:0] hit_w;

    pin_st_t st_d, st_q;

    fgo_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (wrap_w),
        .act     (cfg_act)
    );

    fgo_state_ctr #(
        .CNT_W     (CNT_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_w),
        .wrap  (wrap_w)
    );

    assign qty_w = {cfg_act.low[QHI_W-1:0], cfg_act.start};

    fgo_pulse_match #(
        .CNT_W     (CNT_W),
        .FRAME_LEN (FRAME_LEN),
        .SPACING   (SPACING)
    ) u_match (
        .qty (qty_w),
        .cnt (cnt_w),
        .hit (hit_w)
    );

    always_comb begin
        st_d = st_q;
        unique case (cfg_act.sel)
            FG_PROG: st_d.pins = {cfg_act.low, cfg_act.start};
            FG_OE:   st_d.pins = {strm_oe, cfg_act.low};
            FG_NORM: st_d.pins = hit_w;
            FG_INV:  st_d.pins = ~hit_w;
            default: st_d.pins = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fg_pins = st_q.pins;

endmodule

// File: rtl/fgo_chk.sv
module fgo_chk
    import fgo_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int FRAME_LEN = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    input  cfg_t              act,
    input  logic [STRM_N-1:0] strm_oe,
    input  logic [PIN_N-1:0]  pins
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    assert_ctr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_ctr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act));

    assert_prog_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act.sel == FG_PROG) |=> (pins == {$past(act.low), $past(act.start)}));

    assert_oe_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act.sel == FG_OE) |=> (pins == {$past(strm_oe), $past(act.low)}));

    assert_norm_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act.sel == FG_NORM) |=> $onehot0(pins));

    assert_inv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act.sel == FG_INV) |=> $onehot0(~pins));

endmodule

bind fgo_frame_group fgo_chk #(
    .CNT_W     (CNT_W),
    .FRAME_LEN (FRAME_LEN)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt_w),
    .wrap    (wrap_w),
    .act     (cfg_act),
    .strm_oe (strm_oe),
    .pins    (fg_pins)
);

// File: tb/fgo_frame_group_tb.sv
module fgo_frame_group_tb_top;

    localparam int CLK_P = 10;
    localparam int FL    = 64;
    localparam int SP    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  strm_oe = '0;
    logic [11:0] fg_pins;

    int total = 0;
    int bad   = 0;
    int bc    = 0;

    always #(CLK_P / 2) clk = ~clk;

    fgo_frame_group #(
        .CNT_W     (11),
        .FRAME_LEN (FL),
        .SPACING   (SP)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .strm_oe (strm_oe),
        .fg_pins (fg_pins)
    );

    // Frame position per R6, followed independently of the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc <= 0;
        else        bc <= (bc == FL - 1) ? 0 : bc + 1;
    end

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s state=%0d got=%h exp=%h", req, bc, got, exp);
        end
    endtask

    task automatic wait_state(input int s);
        do @(negedge clk); while (bc != s);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write mid-frame, then stop at state 0 of the frame that uses it.
    task automatic apply(input logic [7:0] st, input logic [7:0] md);
        wait_state(10);
        wr(1'b0, st);
        wr(1'b1, md);
        wait_state(0);
    endtask

    // Checks every state of one frame: states 1..63, then state 0.
    task automatic frame_check(input string req, input int q, input bit inv);
        for (int s = 1; s <= FL; s++) begin
            logic [11:0] exp;
            int prev;
            wait_state(s % FL);
            prev = s - 1;
            exp  = '0;
            for (int k = 0; k < 12; k++) begin
                if (((q + k * SP) % FL) == prev) exp[k] = 1'b1;
            end
            if (inv) exp = ~exp;
            check(req, fg_pins, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset pins", fg_pins, 12'h000);
        wait_state(5);
        check("R1 idle prog mode", fg_pins, 12'h000);
    endtask

    task automatic t_defer;
        wait_state(10);
        wr(1'b0, 8'hA5);
        wr(1'b1, 8'h0C);
        wait_state(FL - 1);
        check("R9 old before wrap", fg_pins, 12'h000);
        wait_state(0);
        check("R9 old at state 0", fg_pins, 12'h000);
        wait_state(1);
        check("R9 R3 new at state 1", fg_pins, 12'hCA5);
    endtask

    task automatic t_reserved;
        apply(8'h3C, 8'h3A);
        wait_state(2);
        check("R2 R3 reserved bits set", fg_pins, 12'hA3C);
        apply(8'h3C, 8'h0A);
        wait_state(2);
        check("R2 reserved bits clear", fg_pins, 12'hA3C);
    endtask

    task automatic t_oe;
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h81, 8'h5A};
        apply(8'hFF, 8'h45);
        for (int i = 0; i < 4; i++) begin
            strm_oe = pats[i];
            @(negedge clk);
            check("R4 R10 stream enables", fg_pins, {pats[i], 4'h5});
        end
        strm_oe = 8'h00;
    endtask

    task automatic t_frames;
        apply(8'h0A, 8'h80);
        frame_check("R7 normal q=10", 10, 1'b0);
        apply(8'hE8, 8'h83);
        frame_check("R5 R7 high bits q=1000", 1000, 1'b0);
        apply(8'h3B, 8'h80);
        frame_check("R7 R6 wrap q=59", 59, 1'b0);
        apply(8'h0A, 8'hC0);
        frame_check("R8 inverted q=10", 10, 1'b1);
        apply(8'h3F, 8'hC8);
        frame_check("R8 R2 inverted q=63", 63, 1'b1);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_defer();
        t_reserved();
        t_oe();
        t_frames();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule